// File: doc/BRIEF.md
# Asynchronous memory strobe timer

This block generates the four active-low control strobes of one chip select on an asynchronous external memory: chip select, address valid, output enable and write enable. Software programs each edge position as a time value through a single-field write port. The block rounds the time up to whole interface-clock ticks, rejects any value that does not fit its field, and packs accepted values into four 32-bit timing words. The words can be read back through a combinational read port.

A one-cycle start pulse begins an access and says whether it is a read or a write. The block then counts ticks from zero. Each strobe is low from its programmed on tick up to, but not including, its off tick. The off tick is taken from the read or the write variant of the field. When the count reaches the programmed read or write cycle length, all strobes return high and a one-cycle done pulse is given. Start requests are ignored while an access is running.

Top module: `xmem_strobe_timer`

## Requirements
- R1: While reset is held and after its release, all four strobes are high, `acc_done` and `fld_err` are low, and all four timing words read back as zero.
- R2: Field codes on `fld_id` and their places in the timing words (word index on `cfg_rsel`) are as follows. Word 0 is chip select: 0 = on tick [3:0], 1 = read off [12:8], 2 = write off [20:16]. Word 1 is address valid: 3 = on [3:0], 4 = read off [12:8], 5 = write off [20:16]. Word 2 holds the two enables: 6 = output-enable on [3:0], 7 = output-enable off [12:8], 8 = write-enable on [19:16], 9 = write-enable off [28:24]. Word 3 holds the lengths: 10 = read cycle length [4:0], 11 = write cycle length [12:8], 12 = access time [20:16]. A write changes only its own field, and all other bits of the words stay zero.
- R3: `fld_time` counts in quarter ticks (FRAC_W = 2). The stored tick count is the time rounded up to the next whole tick, so 0 gives 0, 1 to 4 give 1 and 5 gives 2.
- R4: A write is rejected if its rounded tick count does not fit the field width, or if its code is 13, 14 or 15. A rejected write leaves all four words unchanged, and `fld_err` is high for exactly the cycle after it.
- R5: When `acc_start` is seen while idle, `acc_wr` is captured (1 = write). The tick count is 0 in the cycle after that edge and rises by one per clock. A strobe is low in every cycle whose tick count k satisfies on <= k < off. For chip select and address valid, the off value is the read or the write off field, chosen by the captured direction.
- R6: Output enable can go low only in read accesses, and write enable only in write accesses.
- R7: A strobe whose off value is less than or equal to its on value stays high for the whole access.
- R8: With L the programmed length for the access direction and a length of 0 taken as 1, the access spans tick counts 0 to L-1. In the next cycle `acc_done` is high for one cycle and all strobes are high.
- R9: `acc_start` is ignored while an access is running, including in its last tick. The direction and tick sequence of the running access do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fld_we | input | 1 | Field write strobe |
| fld_id | input | 4 | Field code, see R2 |
| fld_time | input | TIME_W | Field time in 1/2^FRAC_W tick units |
| fld_err | output | 1 | Rejected-write pulse |
| cfg_rsel | input | 2 | Timing word select for readback |
| cfg_rdata | output | 32 | Selected timing word |
| acc_start | input | 1 | Access start request |
| acc_wr | input | 1 | Access direction, 1 = write |
| acc_done | output | 1 | End-of-access pulse |
| mem_cs_n | output | 1 | Chip select strobe, active low |
| mem_adv_n | output | 1 | Address valid strobe, active low |
| mem_oe_n | output | 1 | Output enable strobe, active low |
| mem_we_n | output | 1 | Write enable strobe, active low |

## Verification
A field write driven before clock edge E updates the word and `fld_err` at E. The bench therefore samples both at the next falling edge, and it reads every word back combinationally at that point. A start seen at edge E gives tick count 0 for the strobes right after E, count k after edge E+k, and `acc_done` after edge E+L. The bench checks all strobes and done at each falling edge from count 0 to L. Extra start pulses are placed only on ticks where the access is still running, so each one must be ignored.

// File: rtl/xst_pkg.sv
package xst_pkg;

  localparam int NUM_FIELDS  = 13;
  localparam int NUM_WORDS   = 4;
  localparam int WORD_W      = 32;
  localparam int NUM_STROBES = 4;
  localparam int TICK_FW     = 5;   // widest tick field
  localparam int SEL_W       = $clog2(NUM_WORDS);

  localparam int STB_CS = 0;
  localparam int STB_AV = 1;
  localparam int STB_OE = 2;
  localparam int STB_WE = 3;

  typedef struct packed {
    logic [TICK_FW-1:0] on_t;
    logic [TICK_FW-1:0] off_rd;
    logic [TICK_FW-1:0] off_wr;
  } strobe_cfg_t;

  // word index holding a field
  function automatic logic [SEL_W-1:0] fld_word(input logic [3:0] id);
    case (id)
      4'd0, 4'd1, 4'd2:              fld_word = 2'd0;
      4'd3, 4'd4, 4'd5:              fld_word = 2'd1;
      4'd6, 4'd7, 4'd8, 4'd9:        fld_word = 2'd2;
      default:                       fld_word = 2'd3;
    endcase
  endfunction

  // least significant bit of a field inside its word
  function automatic logic [4:0] fld_lsb(input logic [3:0] id);
    case (id)
      4'd1, 4'd4, 4'd7, 4'd11:       fld_lsb = 5'd8;
      4'd2, 4'd5, 4'd8, 4'd12:       fld_lsb = 5'd16;
      4'd9:                          fld_lsb = 5'd24;
      default:                       fld_lsb = 5'd0;
    endcase
  endfunction

  // field width: on ticks are narrow, off ticks and lengths are wide
  function automatic logic [2:0] fld_width(input logic [3:0] id);
    case (id)
      4'd0, 4'd3, 4'd6, 4'd8:        fld_width = 3'd4;
      default:                       fld_width = 3'd5;
    endcase
  endfunction

endpackage

// File: rtl/xst_rst_sync.sv
module xst_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/xst_field_regs.sv
module xst_field_regs
  import xst_pkg::*;
#(
  parameter int TIME_W = 12,
  parameter int FRAC_W = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fld_we,
  input  logic [3:0]                     fld_id,
  input  logic [TIME_W-1:0]              fld_time,
  output logic [NUM_WORDS-1:0][WORD_W-1:0] words,
  output logic                           fld_err
);
  localparam int TICK_W = TIME_W - FRAC_W + 1;

  logic [TICK_W-1:0]    ticks;
  logic                 frac_nz;
  logic                 id_ok;
  logic                 fits;
  logic                 wr_ok;
  logic [SEL_W-1:0]     sel;
  logic [4:0]           lsb;
  logic [2:0]           width;
  logic [WORD_W-1:0]    mask;
  logic [WORD_W-1:0]    word_d;
  logic [NUM_WORDS-1:0] word_en;
  logic                 err_d;
  logic [NUM_WORDS-1:0][WORD_W-1:0] words_q;

  // round up to whole ticks: integer part plus one if any fraction
  assign frac_nz = |fld_time[FRAC_W-1:0];
  assign ticks   = TICK_W'(fld_time >> FRAC_W) + TICK_W'(frac_nz);

  always_comb begin
    sel    = fld_word(fld_id);
    lsb    = fld_lsb(fld_id);
    width  = fld_width(fld_id);
    id_ok  = (fld_id < 4'(NUM_FIELDS));
    fits   = ((ticks >> width) == '0);
    wr_ok  = fld_we && id_ok && fits;
    err_d  = fld_we && !(id_ok && fits);
    mask   = ((WORD_W'(1) << width) - WORD_W'(1)) << lsb;
    word_d = (words_q[sel] & ~mask) | ((WORD_W'(ticks[TICK_FW-1:0]) << lsb) & mask);
  end

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_en
    assign word_en[k] = wr_ok && (sel == SEL_W'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q <= '0;
      fld_err <= 1'b0;
    end else begin
      fld_err <= err_d;
      for (int k = 0; k < NUM_WORDS; k++) begin
        if (word_en[k]) words_q[k] <= word_d;
      end
    end
  end

  assign words = words_q;
endmodule

// File: rtl/xst_cycle_ctr.sv
module xst_cycle_ctr
  import xst_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               start_wr,
  input  logic [TICK_FW-1:0] rd_len,
  input  logic [TICK_FW-1:0] wr_len,
  output logic               busy_d,
  output logic [TICK_FW-1:0] cnt_d,
  output logic               rw_d,
  output logic               busy_q,
  output logic [TICK_FW-1:0] cnt_q,
  output logic               rw_q,
  output logic               done_q
);
  logic             done_d;
  logic             ctr_en;
  logic [TICK_FW:0] nxt;
  logic [TICK_FW:0] len;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    rw_d   = rw_q;
    done_d = 1'b0;
    len    = {1'b0, (rw_q ? wr_len : rd_len)};
    nxt    = {1'b0, cnt_q} + 1'b1;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        rw_d   = start_wr;
      end
    end else if (nxt >= len) begin
      // last tick done; a zero length behaves as one tick
      busy_d = 1'b0;
      cnt_d  = '0;
      done_d = 1'b1;
    end else begin
      cnt_d  = nxt[TICK_FW-1:0];
    end
  end

  assign ctr_en = start || busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rw_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (ctr_en) begin
        busy_q <= busy_d;
        cnt_q  <= cnt_d;
        rw_q   <= rw_d;
      end
    end
  end
endmodule

// File: rtl/xst_strobe_lane.sv
module xst_strobe_lane
  import xst_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_cfg_t        cfg,
  input  logic               busy_d,
  input  logic [TICK_FW-1:0] cnt_d,
  input  logic               rw_d,
  output logic               strobe_n
);
  logic [TICK_FW-1:0] off_sel;
  logic               act_d;

  always_comb begin
    off_sel = rw_d ? cfg.off_wr : cfg.off_rd;
    // empty window when off <= on
    act_d   = busy_d && (cnt_d >= cfg.on_t) && (cnt_d < off_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_n <= 1'b1;
    else        strobe_n <= !act_d;
  end
endmodule

// File: rtl/xmem_strobe_timer.sv
module xmem_strobe_timer
  import xst_pkg::*;
#(
  parameter int TIME_W = 12,
  parameter int FRAC_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fld_we,
  input  logic [3:0]        fld_id,
  input  logic [TIME_W-1:0] fld_time,
  output logic              fld_err,
  input  logic [1:0]        cfg_rsel,
  output logic [31:0]       cfg_rdata,
  input  logic              acc_start,
  input  logic              acc_wr,
  output logic              acc_done,
  output logic              mem_cs_n,
  output logic              mem_adv_n,
  output logic              mem_oe_n,
  output logic              mem_we_n
);
  logic                             rst_n_sync;
  logic [NUM_WORDS-1:0][WORD_W-1:0] words;
  strobe_cfg_t                      cfg [NUM_STROBES];
  logic                             busy_d, busy_q, rw_d, rw_q;
  logic [TICK_FW-1:0]               cnt_d, cnt_q;
  logic [NUM_STROBES-1:0]           strobes_n;

  xst_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  xst_field_regs #(.TIME_W(TIME_W), .FRAC_W(FRAC_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .fld_we   (fld_we),
    .fld_id   (fld_id),
    .fld_time (fld_time),
    .words    (words),
    .fld_err  (fld_err)
  );

  assign cfg_rdata = words[cfg_rsel];

  // unpack the timing words into per-strobe windows
  always_comb begin
    cfg[STB_CS] = '{on_t: {1'b0, words[0][3:0]}, off_rd: words[0][12:8], off_wr: words[0][20:16]};
    cfg[STB_AV] = '{on_t: {1'b0, words[1][3:0]}, off_rd: words[1][12:8], off_wr: words[1][20:16]};
    cfg[STB_OE] = '{on_t: {1'b0, words[2][3:0]}, off_rd: words[2][12:8], off_wr: '0};
    cfg[STB_WE] = '{on_t: {1'b0, words[2][19:16]}, off_rd: '0, off_wr: words[2][28:24]};
  end

  xst_cycle_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .start    (acc_start),
    .start_wr (acc_wr),
    .rd_len   (words[3][4:0]),
    .wr_len   (words[3][12:8]),
    .busy_d   (busy_d),
    .cnt_d    (cnt_d),
    .rw_d     (rw_d),
    .busy_q   (busy_q),
    .cnt_q    (cnt_q),
    .rw_q     (rw_q),
    .done_q   (acc_done)
  );

  for (genvar i = 0; i < NUM_STROBES; i++) begin : g_lane
    xst_strobe_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n_sync),
      .cfg      (cfg[i]),
      .busy_d   (busy_d),
      .cnt_d    (cnt_d),
      .rw_d     (rw_d),
      .strobe_n (strobes_n[i])
    );
  end

  assign mem_cs_n  = strobes_n[STB_CS];
  assign mem_adv_n = strobes_n[STB_AV];
  assign mem_oe_n  = strobes_n[STB_OE];
  assign mem_we_n  = strobes_n[STB_WE];
endmodule

// File: rtl/xst_checker.sv
module xst_checker
  import xst_pkg::*;
(
  input logic                             clk,
  input logic                             rst_n,
  input logic                             start,
  input logic                             busy_q,
  input logic [TICK_FW-1:0]               cnt_q,
  input logic                             rw_q,
  input logic                             done,
  input logic [NUM_STROBES-1:0]           strobes_n,
  input logic                             fld_err,
  input logic [NUM_WORDS-1:0][WORD_W-1:0] words
);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (&strobes_n));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy_q));

  assert_start_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start) |=> (busy_q && cnt_q == '0));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> (!busy_q || (cnt_q == $past(cnt_q) + 5'd1 && rw_q == $past(rw_q))));

  assert_reject_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fld_err |-> $stable(words));

  assert_no_we_in_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !rw_q) |-> strobes_n[STB_WE]);

  assert_no_oe_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rw_q) |-> strobes_n[STB_OE]);
endmodule

bind xmem_strobe_timer xst_checker u_xst_checker (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .start     (acc_start),
  .busy_q    (busy_q),
  .cnt_q     (cnt_q),
  .rw_q      (rw_q),
  .done      (acc_done),
  .strobes_n (strobes_n),
  .fld_err   (fld_err),
  .words     (words)
);

// File: tb/tb_xmem_strobe_timer.sv
`timescale 1ns/100ps
module tb_xmem_strobe_timer;
  localparam int TIME_W = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              fld_we;
  logic [3:0]        fld_id;
  logic [TIME_W-1:0] fld_time;
  logic              fld_err;
  logic [1:0]        cfg_rsel;
  logic [31:0]       cfg_rdata;
  logic              acc_start, acc_wr, acc_done;
  logic              mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n;

  int checks = 0;
  int errors = 0;
  logic [31:0] sh [4];

  always #2 clk = ~clk;

  xmem_strobe_timer #(.TIME_W(TIME_W), .FRAC_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .fld_we(fld_we), .fld_id(fld_id), .fld_time(fld_time),
    .fld_err(fld_err), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
    .acc_start(acc_start), .acc_wr(acc_wr), .acc_done(acc_done),
    .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // field table from R2
  function automatic int f_word(input int id);
    if (id <= 2) return 0;
    if (id <= 5) return 1;
    if (id <= 9) return 2;
    return 3;
  endfunction
  function automatic int f_lsb(input int id);
    case (id)
      1, 4, 7, 11: return 8;
      2, 5, 8, 12: return 16;
      9:           return 24;
      default:     return 0;
    endcase
  endfunction
  function automatic int f_w(input int id);
    return (id == 0 || id == 3 || id == 6 || id == 8) ? 4 : 5;
  endfunction
  function automatic int get(input int id);
    return int'((sh[f_word(id)] >> f_lsb(id)) & ((32'd1 << f_w(id)) - 1));
  endfunction

  task automatic read_all(input string tag);
    for (int w = 0; w < 4; w++) begin
      cfg_rsel = 2'(w);
      #0.2;
      check(cfg_rdata == sh[w], tag, int'(cfg_rdata), int'(sh[w]));
    end
  endtask

  task automatic wr_field(input int id, input int t);
    int  tk;
    bit  ok;
    @(negedge clk);
    fld_we = 1'b1; fld_id = 4'(id); fld_time = TIME_W'(t);
    @(negedge clk);
    fld_we = 1'b0;
    tk = (t + 3) / 4;                      // R3 round up
    ok = (id < 13) && (tk < (1 << f_w(id)));
    check(fld_err == !ok, "R4 fld_err", int'(fld_err), int'(!ok));
    if (ok) begin
      sh[f_word(id)] = (sh[f_word(id)] & ~(((32'd1 << f_w(id)) - 1) << f_lsb(id)))
                     | (32'(tk) << f_lsb(id));
      read_all("R2 R3 readback");
    end else begin
      read_all("R4 words unchanged");
    end
  endtask

  task automatic run_cycle(input bit rw, input int poke_at);
    int  len, lp, on_c, off_c, on_a, off_a;
    bit  cs, av, oe, we;
    logic [3:0] exp_s, got_s;
    len = rw ? get(11) : get(10);
    lp  = (len == 0) ? 1 : len;
    on_c = get(0); off_c = rw ? get(2) : get(1);
    on_a = get(3); off_a = rw ? get(5) : get(4);
    @(negedge clk);
    acc_start = 1'b1; acc_wr = rw;
    @(posedge clk);
    for (int j = 0; j <= lp; j++) begin
      @(negedge clk);
      cs = (j < lp) && j >= on_c && j < off_c;
      av = (j < lp) && j >= on_a && j < off_a;
      oe = (j < lp) && !rw && j >= get(6) && j < get(7);
      we = (j < lp) && rw && j >= get(8) && j < get(9);
      exp_s = ~{we, oe, av, cs};
      got_s = {mem_we_n, mem_oe_n, mem_adv_n, mem_cs_n};
      check(got_s == exp_s, "R5 R6 R7 R9 strobes", int'(got_s), int'(exp_s));
      check(acc_done == (j == lp), "R8 R9 done", int'(acc_done), int'(j == lp));
      acc_start = (j == poke_at) && (j < lp);
      acc_wr    = 1'(~rw);
    end
    acc_start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int w = 0; w < 4; w++) sh[w] = '0;
    rst_n = 1'b0; fld_we = 1'b0; fld_id = '0; fld_time = '0;
    cfg_rsel = '0; acc_start = 1'b0; acc_wr = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check({mem_we_n, mem_oe_n, mem_adv_n, mem_cs_n} == 4'hf, "R1 strobes in reset",
          int'({mem_we_n, mem_oe_n, mem_adv_n, mem_cs_n}), 15);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(acc_done == 1'b0 && fld_err == 1'b0, "R1 done/err", int'({acc_done, fld_err}), 0);
    read_all("R1 words zero");

    // R3 rounding and R2 placement, directed
    wr_field(0, 5);      // 2 ticks
    wr_field(1, 24);     // 6
    wr_field(2, 13);     // 4
    wr_field(3, 0);      // 0
    wr_field(4, 4);      // 1
    wr_field(5, 8);      // 2
    wr_field(6, 1);      // 1
    wr_field(7, 28);     // 7
    wr_field(8, 4);      // 1
    wr_field(9, 20);     // 5
    wr_field(10, 36);    // 9
    wr_field(11, 28);    // 7
    wr_field(12, 124);   // 31, largest fitting 5-bit value
    // R4 rejections
    wr_field(0, 61);     // 16 ticks, does not fit 4 bits
    wr_field(1, 125);    // 32 ticks
    wr_field(13, 4);     // bad code
    wr_field(15, 0);
    run_cycle(1'b0, 3);
    run_cycle(1'b1, 6);  // R9 poke on the last tick
    // R7 empty window: chip select off equal to on, address off below on
    wr_field(1, 8);      // cs read off 2 == on 2
    wr_field(3, 12);     // av on 3 > av read off 1
    run_cycle(1'b0, -1);
    // R8 zero length counts as one tick
    wr_field(10, 0);
    run_cycle(1'b0, 0);
    wr_field(11, 124);   // 31 ticks
    run_cycle(1'b1, 30);

    for (int it = 0; it < 40; it++) begin
      for (int k = 0; k < 3; k++) wr_field(int'($urandom % 15), int'($urandom % 160));
      run_cycle(1'($urandom % 2), int'($urandom % 34));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule